// File: doc/BRIEF.md
# Snooped Direct-Mapped Data Cache

This block is a small direct-mapped first-level data cache placed in front of a CPU load/store port. It holds a backing memory model with two regions. The on-chip RAM region (address bit 10 = 0) can also be written by a DMA master. The external region (address bit 10 = 1) is reached only through the cache. Lines are 64 bytes. Address bits 5:2 select the 32-bit word, bits 9:6 select the line inside a region, and bits 7:6 select one of the four cache sets. An on-chip line and an external line with equal bits 7:6 therefore compete for the same set. The cache is write-back and write-allocate.

DMA writes go straight into on-chip RAM and never stall. When the line written by a DMA write is held in the cache, the same bytes are also written into the cached copy (a snoop write), so the CPU never reads stale data. Software can run a writeback-invalidate over a run of lines. Dirty lines in the run are written back, every matching line is dropped, and a done pulse marks the end of the run.

A DMA write can land on a set that a line fill is about to overwrite. In that case the fill waits exactly one cycle, and when it proceeds it takes no bytes that were meant for the line it evicts.

Top module: `snoopCache`

## Requirements
- R1: After reset, cpuReady, wbiDone and snoopHit are low and every set is empty. Each backing word holds 0xA500_0000 OR (byte address >> 2).
- R2: A CPU read that misses allocates the line. A clean miss raises cpuReady two cycles after cpuValid rises and returns the backing word. A hit raises cpuReady in the same cycle as cpuValid.
- R3: A DMA write to an on-chip line held in the cache raises snoopHit in that cycle, and the cached copy is updated. A later CPU read hits and returns the new bytes.
- R4: Bit i of a byte-enable mask (cpuBe or dmaBe) selects bits 8i+7:8i. Disabled bytes keep their value, and a snoop write does not mark the line dirty.
- R5: A DMA write to an on-chip line that is not cached leaves snoopHit low and still updates the RAM. The next CPU read of that line misses and returns the new data.
- R6: Writeback-invalidate takes a start line (wbiAddr bits 10:6) and a count, and processes one line per cycle. wbiDone is a single-cycle pulse count+1 cycles after the cycle in which wbiStart is taken while idle. A count of 0 pulses in the next cycle.
- R7: Writeback-invalidate writes dirty lines back and drops every line in the range. Later DMA writes there leave snoopHit low, and later CPU reads miss and return the data written earlier.
- R8: An on-chip line and an external line with the same bits 7:6 share a set. Filling one evicts the other, so the next access to the evicted line misses.
- R9: CPU stores stay in the cache until eviction. A miss whose victim is dirty first writes the victim back, which adds one stall cycle (cpuReady three cycles after cpuValid).
- R10: A DMA write whose set equals that of a pending fill holds the fill for exactly one cycle. The filled line never takes bytes aimed at the evicted line. A DMA write to the line being filled lands in the filled copy.
- R11: cpuReady is only ever raised while cpuValid is high, and never in a cycle where wbiDone is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | CPU request present; address and data held until cpuReady |
| cpuWrite | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 11 | CPU byte address |
| cpuWdata | input | 32 | Store data |
| cpuBe | input | 4 | Store byte enables |
| cpuReady | output | 1 | Request completes in this cycle |
| cpuRdata | output | 32 | Load data, valid with cpuReady |
| dmaValid | input | 1 | DMA write into on-chip RAM, taken every cycle |
| dmaAddr | input | 10 | On-chip byte address of the DMA write |
| dmaWdata | input | 32 | DMA write data |
| dmaBe | input | 4 | DMA byte enables |
| snoopHit | output | 1 | The DMA write of this cycle updates cache contents |
| wbiStart | input | 1 | Start a writeback-invalidate run |
| wbiAddr | input | 11 | Byte address inside the first line of the run |
| wbiCount | input | 6 | Number of lines in the run |
| wbiDone | output | 1 | One-cycle pulse at the end of the run |

## Verification
A stale or lost valid or tag bit shows up at the very next access to that set, because the stall length gives it away: 0 extra cycles for a hit, 2 for a clean miss, 3 for a dirty miss or a held fill. Corrupted line data appears only when the corrupted word is read back. The scenarios therefore read the exact word that a misrouted snoop or a dropped byte merge would damage. A lost writeback stays hidden until the line has been evicted or invalidated and then refetched, so every writeback case forces that round trip before comparing.

// File: rtl/snoopCachePkg.sv
package snoopCachePkg;
  localparam int DATA_W = 32;
  localparam int BE_W = DATA_W / 8;
  localparam int LINE_BYTES = 64;
  localparam int LINE_WORDS = LINE_BYTES / BE_W;
  localparam logic [DATA_W-1:0] INIT_BASE = 32'hA500_0000;

  typedef struct packed {
    logic wrHit;      // CPU store into a hitting line
    logic writeBack;  // copy victim line of the CPU set to memory
    logic fill;       // load the CPU line into its set
    logic wbiLine;    // writeback-invalidate the current run line
  } ctrlStrobesT;

  function automatic logic [DATA_W-1:0] byteMerge(input logic [DATA_W-1:0] oldW,
                                                  input logic [DATA_W-1:0] newW,
                                                  input logic [BE_W-1:0] be);
    logic [DATA_W-1:0] r;
    r = oldW;
    for (int b = 0; b < BE_W; b++) begin
      if (be[b]) r[8*b +: 8] = newW[8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/snoopCacheCtrl.sv
module snoopCacheCtrl
  import snoopCachePkg::*;
#(
  parameter int LINE_W = 5,
  parameter int CNT_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic              cpuHit,
  input  logic              victimDirty,
  input  logic              dmaSetCollide,
  input  logic              wbiStart,
  input  logic [LINE_W-1:0] wbiStartLine,
  input  logic [CNT_W-1:0]  wbiCount,
  output ctrlStrobesT       strobes,
  output logic [LINE_W-1:0] wbiLine,
  output logic              cpuReady,
  output logic              wbiDone
);
  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_WBI} stateT;

  stateT state, nextState;
  logic fillHeld;
  logic [CNT_W-1:0] linesLeft;

  always_comb begin
    strobes = '0;
    cpuReady = 1'b0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (wbiStart) begin
          nextState = S_WBI;
        end else if (cpuValid) begin
          if (cpuHit) begin
            cpuReady = 1'b1;
            strobes.wrHit = cpuWrite;
          end else begin
            nextState = victimDirty ? S_WB : S_FILL;
          end
        end
      end
      S_WB: begin
        strobes.writeBack = 1'b1;
        nextState = S_FILL;
      end
      S_FILL: begin
        if (!(dmaSetCollide && !fillHeld)) begin
          strobes.fill = 1'b1;
          nextState = S_IDLE;
        end
      end
      S_WBI: begin
        if (linesLeft == '0) nextState = S_IDLE;
        else strobes.wbiLine = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign wbiDone = (state == S_WBI) && (linesLeft == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      fillHeld <= 1'b0;
      linesLeft <= '0;
      wbiLine <= '0;
    end else begin
      state <= nextState;
      fillHeld <= (state == S_FILL) && dmaSetCollide && !fillHeld;
      if (state == S_IDLE && wbiStart) begin
        linesLeft <= wbiCount;
        wbiLine <= wbiStartLine;
      end else if (strobes.wbiLine) begin
        linesLeft <= linesLeft - CNT_W'(1);
        wbiLine <= wbiLine + LINE_W'(1);
      end
    end
  end
endmodule

// File: rtl/snoopCacheDatapath.sv
module snoopCacheDatapath
  import snoopCachePkg::*;
#(
  parameter int SETS = 4,
  parameter int REGION_LINES = 16,
  localparam int SET_W = $clog2(SETS),
  localparam int IDX_W = $clog2(REGION_LINES),
  localparam int LINE_W = IDX_W + 1,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int WORD_W = $clog2(LINE_WORDS),
  localparam int ADDR_W = LINE_W + OFS_W,
  localparam int DMA_ADDR_W = IDX_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobesT           strobes,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [BE_W-1:0]       cpuBe,
  input  logic                  dmaValid,
  input  logic [DMA_ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0]     dmaWdata,
  input  logic [BE_W-1:0]       dmaBe,
  input  logic [LINE_W-1:0]     wbiLine,
  output logic                  cpuHit,
  output logic                  victimDirty,
  output logic                  dmaSetCollide,
  output logic [DATA_W-1:0]     cpuRdata,
  output logic                  snoopHit
);
  localparam int TAG_W = LINE_W - SET_W;
  localparam int MEM_WORDS = 2 * REGION_LINES * LINE_WORDS;

  logic [DATA_W-1:0] memArr [MEM_WORDS];
  logic [DATA_W-1:0] cacheData [SETS][LINE_WORDS];
  logic [TAG_W-1:0]  tagArr [SETS];
  logic [SETS-1:0]   validArr, dirtyArr;

  logic [LINE_W-1:0] cpuLine, dmaLine, victimLine;
  logic [SET_W-1:0]  cpuSet, dmaSet, wbiSet;
  logic [TAG_W-1:0]  cpuTag, dmaTag, wbiTag;
  logic [WORD_W-1:0] cpuWord, dmaWord;
  logic dmaCached, snoopApply, fillMerge, wbiMatch, wbiWrite;
  logic [DATA_W-1:0] cpuMerged, snoopBase, memBase;
  logic [DATA_W-1:0] fillData [LINE_WORDS];
  logic unusedLowBits;

  assign unusedLowBits = ^{cpuAddr[1:0], dmaAddr[1:0]};

  assign cpuLine = cpuAddr[ADDR_W-1:OFS_W];
  assign cpuSet = cpuLine[SET_W-1:0];
  assign cpuTag = cpuLine[LINE_W-1:SET_W];
  assign cpuWord = cpuAddr[OFS_W-1:2];
  assign dmaLine = {1'b0, dmaAddr[DMA_ADDR_W-1:OFS_W]};
  assign dmaSet = dmaLine[SET_W-1:0];
  assign dmaTag = dmaLine[LINE_W-1:SET_W];
  assign dmaWord = dmaAddr[OFS_W-1:2];
  assign wbiSet = wbiLine[SET_W-1:0];
  assign wbiTag = wbiLine[LINE_W-1:SET_W];
  assign victimLine = {tagArr[cpuSet], cpuSet};

  assign cpuHit = validArr[cpuSet] && (tagArr[cpuSet] == cpuTag);
  assign victimDirty = validArr[cpuSet] && dirtyArr[cpuSet];
  assign dmaSetCollide = dmaValid && (dmaSet == cpuSet);
  assign cpuRdata = cacheData[cpuSet][cpuWord];

  // snoop is dropped when the fill replaces its set; a same-line write merges into the fill
  assign dmaCached = dmaValid && validArr[dmaSet] && (tagArr[dmaSet] == dmaTag);
  assign fillMerge = strobes.fill && dmaValid && (dmaLine == cpuLine);
  assign snoopApply = dmaCached && !(strobes.fill && (dmaSet == cpuSet));
  assign snoopHit = snoopApply || fillMerge;

  assign wbiMatch = validArr[wbiSet] && (tagArr[wbiSet] == wbiTag);
  assign wbiWrite = strobes.wbiLine && wbiMatch && dirtyArr[wbiSet];

  assign cpuMerged = byteMerge(cacheData[cpuSet][cpuWord], cpuWdata, cpuBe);
  assign snoopBase = (strobes.wrHit && dmaSet == cpuSet && dmaWord == cpuWord)
                     ? cpuMerged : cacheData[dmaSet][dmaWord];

  always_comb begin
    if (strobes.writeBack && victimLine == dmaLine) memBase = cacheData[cpuSet][dmaWord];
    else if (wbiWrite && wbiLine == dmaLine) memBase = cacheData[wbiSet][dmaWord];
    else memBase = memArr[{dmaLine, dmaWord}];
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_fill
    assign fillData[w] = (fillMerge && dmaWord == WORD_W'(w))
                         ? byteMerge(memArr[{cpuLine, WORD_W'(w)}], dmaWdata, dmaBe)
                         : memArr[{cpuLine, WORD_W'(w)}];
  end

  // backing memory: line copies first, DMA bytes last so they win
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_WORDS; i++) memArr[i] <= INIT_BASE | DATA_W'(i);
    end else begin
      if (strobes.writeBack) begin
        for (int w = 0; w < LINE_WORDS; w++)
          memArr[{victimLine, WORD_W'(w)}] <= cacheData[cpuSet][w];
      end
      if (wbiWrite) begin
        for (int w = 0; w < LINE_WORDS; w++)
          memArr[{wbiLine, WORD_W'(w)}] <= cacheData[wbiSet][w];
      end
      if (dmaValid) memArr[{dmaLine, dmaWord}] <= byteMerge(memBase, dmaWdata, dmaBe);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validArr <= '0;
      dirtyArr <= '0;
      for (int s = 0; s < SETS; s++) tagArr[s] <= '0;
    end else begin
      if (strobes.fill) begin
        validArr[cpuSet] <= 1'b1;
        dirtyArr[cpuSet] <= 1'b0;
        tagArr[cpuSet] <= cpuTag;
      end
      if (strobes.wrHit) dirtyArr[cpuSet] <= 1'b1;
      if (strobes.wbiLine && wbiMatch) begin
        validArr[wbiSet] <= 1'b0;
        dirtyArr[wbiSet] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.fill) begin
      for (int w = 0; w < LINE_WORDS; w++) cacheData[cpuSet][w] <= fillData[w];
    end
    if (strobes.wrHit) cacheData[cpuSet][cpuWord] <= cpuMerged;
    if (snoopApply) cacheData[dmaSet][dmaWord] <= byteMerge(snoopBase, dmaWdata, dmaBe);
  end
endmodule

// File: rtl/snoopCache.sv
module snoopCache
  import snoopCachePkg::*;
#(
  parameter int SETS = 4,
  parameter int REGION_LINES = 16,
  localparam int IDX_W = $clog2(REGION_LINES),
  localparam int LINE_W = IDX_W + 1,
  localparam int OFS_W = $clog2(LINE_BYTES),
  localparam int ADDR_W = LINE_W + OFS_W,
  localparam int DMA_ADDR_W = IDX_W + OFS_W,
  localparam int CNT_W = LINE_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cpuValid,
  input  logic                  cpuWrite,
  input  logic [ADDR_W-1:0]     cpuAddr,
  input  logic [DATA_W-1:0]     cpuWdata,
  input  logic [BE_W-1:0]       cpuBe,
  output logic                  cpuReady,
  output logic [DATA_W-1:0]     cpuRdata,
  input  logic                  dmaValid,
  input  logic [DMA_ADDR_W-1:0] dmaAddr,
  input  logic [DATA_W-1:0]     dmaWdata,
  input  logic [BE_W-1:0]       dmaBe,
  output logic                  snoopHit,
  input  logic                  wbiStart,
  input  logic [ADDR_W-1:0]     wbiAddr,
  input  logic [CNT_W-1:0]      wbiCount,
  output logic                  wbiDone
);
  ctrlStrobesT strobes;
  logic cpuHit, victimDirty, dmaSetCollide;
  logic [LINE_W-1:0] wbiLine;
  logic unusedWbiOfs;

  assign unusedWbiOfs = ^wbiAddr[OFS_W-1:0];

  snoopCacheCtrl #(.LINE_W(LINE_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite),
    .cpuHit(cpuHit), .victimDirty(victimDirty), .dmaSetCollide(dmaSetCollide),
    .wbiStart(wbiStart), .wbiStartLine(wbiAddr[ADDR_W-1:OFS_W]), .wbiCount(wbiCount),
    .strobes(strobes), .wbiLine(wbiLine), .cpuReady(cpuReady), .wbiDone(wbiDone)
  );

  snoopCacheDatapath #(.SETS(SETS), .REGION_LINES(REGION_LINES)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuBe(cpuBe), .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata),
    .dmaBe(dmaBe), .wbiLine(wbiLine), .cpuHit(cpuHit), .victimDirty(victimDirty),
    .dmaSetCollide(dmaSetCollide), .cpuRdata(cpuRdata), .snoopHit(snoopHit)
  );
endmodule

// File: rtl/snoopCacheChecker.sv
module snoopCacheChecker (
  input logic clk,
  input logic rstN,
  input logic cpuValid,
  input logic cpuReady,
  input logic dmaValid,
  input logic snoopHit,
  input logic wbiStart,
  input logic wbiDone
);
  logic wbiPending;

  always_ff @(posedge clk) begin
    if (!rstN) wbiPending <= 1'b0;
    else if (wbiDone) wbiPending <= 1'b0;
    else if (wbiStart) wbiPending <= 1'b1;
  end

  assert_ready_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |-> cpuValid);

  assert_no_ready_at_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(cpuReady && wbiDone));

  assert_snoop_needs_dma_R3: assert property (@(posedge clk) disable iff (!rstN)
    snoopHit |-> dmaValid);

  assert_done_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbiDone |=> !wbiDone);

  assert_done_follows_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    wbiDone |-> wbiPending);
endmodule

bind snoopCache snoopCacheChecker u_chk (
  .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuReady(cpuReady),
  .dmaValid(dmaValid), .snoopHit(snoopHit), .wbiStart(wbiStart), .wbiDone(wbiDone)
);

// File: tb/snoopCache_tb.sv
`timescale 1ns/1ps
module snoopCache_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuValid = 1'b0, cpuWrite = 1'b0;
  logic [10:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic [3:0] cpuBe = '0;
  logic cpuReady;
  logic [31:0] cpuRdata;
  logic dmaValid = 1'b0;
  logic [9:0] dmaAddr = '0;
  logic [31:0] dmaWdata = '0;
  logic [3:0] dmaBe = '0;
  logic snoopHit;
  logic wbiStart = 1'b0;
  logic [10:0] wbiAddr = '0;
  logic [5:0] wbiCount = '0;
  logic wbiDone;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;
  int lat;

  always #10 clk = ~clk;

  snoopCache u_dut (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuWrite(cpuWrite), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuBe(cpuBe), .cpuReady(cpuReady), .cpuRdata(cpuRdata),
    .dmaValid(dmaValid), .dmaAddr(dmaAddr), .dmaWdata(dmaWdata), .dmaBe(dmaBe),
    .snoopHit(snoopHit), .wbiStart(wbiStart), .wbiAddr(wbiAddr), .wbiCount(wbiCount),
    .wbiDone(wbiDone)
  );

  function automatic logic [31:0] initVal(input logic [10:0] a);
    return 32'hA500_0000 | 32'(a >> 2);
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cpuAccess(input logic wr, input logic [10:0] a, input logic [31:0] wd,
                           input logic [3:0] be, output logic [31:0] data, output int stall);
    @(posedge clk); #1;
    cpuValid = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = wd; cpuBe = be;
    stall = 0;
    data = '0;
    forever begin
      @(negedge clk);
      if (cpuReady) begin
        data = cpuRdata;
        break;
      end
      stall++;
      if (stall > 40) break;
    end
    @(posedge clk); #1;
    cpuValid = 1'b0; cpuWrite = 1'b0;
  endtask

  task automatic dmaWrite(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be,
                          output logic hit);
    @(posedge clk); #1;
    dmaValid = 1'b1; dmaAddr = a; dmaWdata = d; dmaBe = be;
    @(negedge clk);
    hit = snoopHit;
    @(posedge clk); #1;
    dmaValid = 1'b0;
  endtask

  task automatic runWbi(input logic [10:0] a, input logic [5:0] n, output int doneAt,
                        output int pulses);
    @(posedge clk); #1;
    wbiStart = 1'b1; wbiAddr = a; wbiCount = n;
    @(posedge clk); #1;
    wbiStart = 1'b0;
    doneAt = 0;
    pulses = 0;
    for (int k = 1; k <= int'(n) + 4; k++) begin
      @(negedge clk);
      if (wbiDone) begin
        pulses++;
        if (doneAt == 0) doneAt = k;
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", "cpuReady idle", 32'(cpuReady), 32'd0);
    check("R1", "wbiDone idle", 32'(wbiDone), 32'd0);
    check("R1", "snoopHit idle", 32'(snoopHit), 32'd0);
  endtask

  task automatic testReadMiss();
    cpuAccess(1'b0, 11'h040, '0, '0, rd, lat);
    check("R1", "first read misses (stall)", 32'(lat), 32'd2);
    check("R2", "miss data", rd, initVal(11'h040));
    cpuAccess(1'b0, 11'h040, '0, '0, rd, lat);
    check("R2", "hit stall", 32'(lat), 32'd0);
    check("R2", "hit data", rd, initVal(11'h040));
  endtask

  task automatic testSnoop();
    logic h;
    dmaWrite(10'h044, 32'h1234_5678, 4'b0011, h);
    check("R3", "snoopHit on cached line", 32'(h), 32'd1);
    cpuAccess(1'b0, 11'h044, '0, '0, rd, lat);
    check("R3", "read after snoop hits", 32'(lat), 32'd0);
    check("R4", "only enabled bytes snooped", rd,
          (initVal(11'h044) & 32'hFFFF_0000) | 32'h0000_5678);
  endtask

  task automatic testUncachedDma();
    logic h;
    dmaWrite(10'h140, 32'hCAFE_F00D, 4'b1111, h);
    check("R5", "no snoop on uncached line", 32'(h), 32'd0);
    cpuAccess(1'b0, 11'h140, '0, '0, rd, lat);
    check("R4", "snooped victim clean, no writeback stall", 32'(lat), 32'd2);
    check("R5", "RAM updated by DMA", rd, 32'hCAFE_F00D);
  endtask

  task automatic testWbi();
    logic h;
    int doneAt, pulses;
    cpuAccess(1'b1, 11'h148, 32'h1122_3344, 4'b1111, rd, lat);
    check("R9", "store hit stall", 32'(lat), 32'd0);
    runWbi(11'h140, 6'd1, doneAt, pulses);
    check("R6", "done timing for 1 line", 32'(doneAt), 32'd2);
    check("R6", "done pulse count", 32'(pulses), 32'd1);
    dmaWrite(10'h14C, 32'h0000_0055, 4'b1111, h);
    check("R7", "no snoop after invalidate", 32'(h), 32'd0);
    cpuAccess(1'b0, 11'h148, '0, '0, rd, lat);
    check("R7", "read after invalidate misses", 32'(lat), 32'd2);
    check("R7", "dirty data written back", rd, 32'h1122_3344);
    runWbi(11'h000, 6'd0, doneAt, pulses);
    check("R6", "done timing for count 0", 32'(doneAt), 32'd1);
  endtask

  task automatic testAlias();
    cpuAccess(1'b0, 11'h000, '0, '0, rd, lat);
    check("R8", "on-chip line 0 data", rd, initVal(11'h000));
    cpuAccess(1'b0, 11'h400, '0, '0, rd, lat);
    check("R8", "external alias miss", 32'(lat), 32'd2);
    check("R8", "external alias data", rd, initVal(11'h400));
    cpuAccess(1'b0, 11'h000, '0, '0, rd, lat);
    check("R8", "evicted line misses again", 32'(lat), 32'd2);
  endtask

  task automatic testDirtyEvict();
    cpuAccess(1'b1, 11'h404, 32'hDEAD_BEEF, 4'b1111, rd, lat);
    check("R9", "store miss allocates", 32'(lat), 32'd2);
    cpuAccess(1'b0, 11'h000, '0, '0, rd, lat);
    check("R9", "dirty victim adds a cycle", 32'(lat), 32'd3);
    check("R9", "fill after writeback data", rd, initVal(11'h000));
    cpuAccess(1'b0, 11'h404, '0, '0, rd, lat);
    check("R9", "written-back external data", rd, 32'hDEAD_BEEF);
  endtask

  task automatic testCollide();
    cpuAccess(1'b0, 11'h0C0, '0, '0, rd, lat);
    check("R10", "prime on-chip line 3", rd, initVal(11'h0C0));
    @(posedge clk); #1;
    dmaValid = 1'b1; dmaAddr = 10'h0C4; dmaWdata = 32'h0BAD_CAFE; dmaBe = 4'b1111;
    cpuAccess(1'b0, 11'h4C4, '0, '0, rd, lat);
    dmaValid = 1'b0;
    check("R10", "fill held one cycle", 32'(lat), 32'd3);
    check("R10", "fill not hit by evicted-line snoop", rd, initVal(11'h4C4));
    cpuAccess(1'b0, 11'h4C4, '0, '0, rd, lat);
    check("R10", "filled word stays clean", rd, initVal(11'h4C4));
    cpuAccess(1'b0, 11'h0C4, '0, '0, rd, lat);
    check("R10", "DMA data reached RAM", rd, 32'h0BAD_CAFE);
    @(posedge clk); #1;
    dmaValid = 1'b1; dmaAddr = 10'h188; dmaWdata = 32'h7766_5544; dmaBe = 4'b1111;
    cpuAccess(1'b0, 11'h188, '0, '0, rd, lat);
    dmaValid = 1'b0;
    check("R10", "same-line fill held", 32'(lat), 32'd3);
    check("R10", "same-line DMA in filled copy", rd, 32'h7766_5544);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testReadMiss();
    testSnoop();
    testUncachedDma();
    testWbi();
    testAlias();
    testDirtyEvict();
    testCollide();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule